// File: doc/BRIEF.md
# Switch Address Lookup Table

This block holds the forwarding table of a small Ethernet switch. Every table slot is a packed 69-bit record carrying an entry kind, a 48-bit MAC address and either unicast attributes (ageing class, secure, blocked, destination port number) or multicast attributes (forward state, destination port mask). Software reaches the slots indirectly. It fills three 32-bit data words and then names a slot index in a table-control register, either to fetch the slot into the words or to commit the words into the slot. Beside the table sit a main control register and one forwarding-state register per switch port.

The block also accepts a hardware placement command. The command carries an address, and either a port number with secure and blocked flags for unicast, or a port mask for multicast. Whether the address is multicast is decided by bit 0 of its first octet. The sequencer walks every slot once. It then writes into the best slot it found, in this priority: a slot that already holds the same MAC, then the first free slot, then the first slot holding an ageable unicast address. If none of these exists, it reports that there is no space. The main control register can also start a table clear, which frees every slot, one per clock.

Top module: `alt_lookup_table`

## Requirements
- R1: After reset the control register, every port-state register, the three data words and every table slot read as zero, and upd_busy, upd_done and upd_nospace are low.
- R2: Register map (byte address): 0x00 control, 0x04 table control, 0x08 data word holding entry bits 68:64 in its low 5 bits with bits 31:5 reading 0, 0x0C data word for bits 63:32, 0x10 data word for bits 31:0. Writing table control with bit 31 clear copies the slot named by its low index bits into the data words one clock later. Writing it with bit 31 set stores the data words into that slot. A data word changes only through these writes.
- R3: Port n has its state register at 0x20+4n. Only bits 1:0 are kept (0 disabled, 1 blocking, 2 learning, 3 forwarding), the rest read 0, and port_state[2n+1:2n] shows the stored value.
- R4: Control bit 31 (enable) and bit 2 (VLAN-aware) are stored as written. Every other control bit reads 0, except bit 30.
- R5: Writing control with bit 30 set, while no command is in progress, clears every slot to all-zero (kind 0, free), one slot per clock. Bit 30 reads 1 from the next clock for exactly DEPTH clocks and then reads 0.
- R6: A unicast placement (upd_mac bit 40 clear) writes a fresh entry. The entry has kind 1 in bits 61:60, the MAC in bits 47:0, class 0 (persistent) in bits 63:62, secure in bit 64, blocked in bit 65 and the port number in bits 67:66. All other bits are zero.
- R7: A slot whose kind is 1 (address) or 3 (VLAN plus address) and whose bits 47:0 equal the command MAC wins over any free slot, even if the free slot has a lower index.
- R8: If no slot holds the same MAC, the lowest free slot is used. If there is no free slot, the lowest slot of kind 1 or 3 with bit 40 clear and class 1 (untouched) or 3 (touched) is used. Class 0 (persistent), class 2 (vendor prefix), multicast slots and kind 2 slots are never taken.
- R9: When no slot qualifies, upd_nospace pulses for one clock instead of upd_done, and the table is left unchanged.
- R10: A multicast placement (upd_mac bit 40 set) keeps every other bit of a matching slot. It sets kind 1 and forward state 3 in bits 63:62, and ORs upd_mask into the port mask in bits 68:66. Without a match, the same fields are written into a zeroed entry.
- R11: upd_valid is ignored while enable is 0, while a placement or clear is in progress, or in the clock a clear is requested.
- R12: upd_done or upd_nospace rises exactly DEPTH clocks after the edge that accepts the command and lasts one clock. The slot is written at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| upd_valid | input | 1 | Placement command request |
| upd_mac | input | 48 | Command MAC address, first octet in bits 47:40 |
| upd_port | input | 2 | Unicast destination port number |
| upd_mask | input | 3 | Multicast destination port mask |
| upd_secure | input | 1 | Unicast secure flag |
| upd_blocked | input | 1 | Unicast blocked flag |
| upd_busy | output | 1 | A placement or clear is in progress |
| upd_done | output | 1 | One-clock pulse: entry placed |
| upd_nospace | output | 1 | One-clock pulse: no qualifying slot |
| port_state | output | 6 | Per-port forwarding state, two bits per port |

## Verification
A candidate slot recorded wrongly during the walk does not show at once. It appears only DEPTH clocks after acceptance, as an entry written to the wrong index or a missing no-space pulse. The directed scenarios therefore read back both the chosen slot and the slot that should have been skipped. A wrong sequencer count shows up as a placement latency other than DEPTH clocks, or as a clear-busy window of the wrong length. Both are timed to the clock. A slip in field packing is caught the first time an entry is fetched through the data words and compared bit for bit.

// File: rtl/alt_pkg.sv
package alt_pkg;
  parameter int ALT_PORTS = 3;
  parameter int ALT_MAC_W = 48;
  localparam int ALT_PNUM_W = (ALT_PORTS > 1) ? $clog2(ALT_PORTS) : 1;
  localparam int ALT_MASK_LSB = 66;
  localparam int ALT_ENTRY_W = ALT_MASK_LSB + ALT_PORTS;
  localparam int ALT_WORD_W = 32;
  localparam int ALT_HI_W = ALT_ENTRY_W - 2 * ALT_WORD_W;

  typedef logic [ALT_ENTRY_W-1:0] alt_entry_t;

  typedef enum logic [1:0] {
    KIND_FREE = 2'd0, KIND_ADDR = 2'd1, KIND_VLAN = 2'd2, KIND_VLAN_ADDR = 2'd3
  } alt_kind_e;

  typedef enum logic [1:0] {
    UC_PERSIST = 2'd0, UC_UNTOUCHED = 2'd1, UC_OUI = 2'd2, UC_TOUCHED = 2'd3
  } alt_uc_e;

  function automatic logic [1:0] kind_of(alt_entry_t e);
    return e[61:60];
  endfunction

  function automatic logic [ALT_MAC_W-1:0] mac_of(alt_entry_t e);
    return e[47:0];
  endfunction

  function automatic logic has_addr(alt_entry_t e);
    return (kind_of(e) == KIND_ADDR) || (kind_of(e) == KIND_VLAN_ADDR);
  endfunction

  function automatic logic is_ageable(alt_entry_t e);
    return has_addr(e) && !e[40] &&
           ((e[63:62] == UC_UNTOUCHED) || (e[63:62] == UC_TOUCHED));
  endfunction

  function automatic alt_entry_t build_ucast(logic [ALT_MAC_W-1:0] mac,
                                             logic [ALT_PNUM_W-1:0] port,
                                             logic sec, logic blk);
    alt_entry_t e;
    e = '0;
    e[61:60] = KIND_ADDR;
    e[47:0]  = mac;
    e[63:62] = UC_PERSIST;
    e[64]    = sec;
    e[65]    = blk;
    e[ALT_MASK_LSB +: ALT_PNUM_W] = port;
    return e;
  endfunction

  function automatic alt_entry_t merge_mcast(alt_entry_t old, logic hit,
                                             logic [ALT_MAC_W-1:0] mac,
                                             logic [ALT_PORTS-1:0] mask);
    alt_entry_t e;
    e = hit ? old : '0;
    e[61:60] = KIND_ADDR;
    e[47:0]  = mac;
    e[63:62] = 2'd3;
    e[ALT_MASK_LSB +: ALT_PORTS] = e[ALT_MASK_LSB +: ALT_PORTS] | mask;
    return e;
  endfunction
endpackage

// File: rtl/alt_store.sv
module alt_store
  import alt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  alt_entry_t       wr_entry,
  input  logic [IDX_W-1:0] a_idx,
  output alt_entry_t       a_entry,
  input  logic [IDX_W-1:0] b_idx,
  output alt_entry_t       b_entry
);
  alt_entry_t slots [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (we) begin
      slots[wr_idx] <= wr_entry;
    end
  end

  assign a_entry = slots[a_idx];
  assign b_entry = slots[b_idx];
endmodule

// File: rtl/alt_placer.sv
module alt_placer
  import alt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  upd_valid,
  input  logic [ALT_MAC_W-1:0]  upd_mac,
  input  logic [ALT_PNUM_W-1:0] upd_port,
  input  logic [ALT_PORTS-1:0]  upd_mask,
  input  logic                  upd_secure,
  input  logic                  upd_blocked,
  input  logic                  clr_req,
  output logic [IDX_W-1:0]      scan_idx,
  input  alt_entry_t            scan_entry,
  output logic                  we,
  output logic [IDX_W-1:0]      wr_idx,
  output alt_entry_t            wr_entry,
  output logic                  busy,
  output logic                  clr_busy,
  output logic                  done,
  output logic                  nospace
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_COMMIT, S_CLEAR} pl_state_e;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  pl_state_e             st;
  logic [IDX_W-1:0]      idx;
  logic [ALT_MAC_W-1:0]  cmd_mac;
  logic [ALT_PNUM_W-1:0] cmd_port;
  logic [ALT_PORTS-1:0]  cmd_mask;
  logic                  cmd_sec, cmd_blk;
  logic                  hit_v, free_v, age_v;
  logic [IDX_W-1:0]      hit_idx, free_idx, age_idx;
  alt_entry_t            hit_ent;

  // named internal events
  logic scan_last, accept, clr_start, cmd_mc, slot_found;
  logic [IDX_W-1:0] target_idx;
  alt_entry_t new_ent;

  assign scan_last  = (st == S_SCAN) && (idx == LAST);
  assign clr_start  = clr_req && (st == S_IDLE);
  assign accept     = upd_valid && en && (st == S_IDLE) && !clr_req;
  assign cmd_mc     = cmd_mac[40];
  assign slot_found = hit_v || free_v || age_v;

  always_comb begin
    if (hit_v)       target_idx = hit_idx;
    else if (free_v) target_idx = free_idx;
    else             target_idx = age_idx;
    new_ent = cmd_mc ? merge_mcast(hit_ent, hit_v, cmd_mac, cmd_mask)
                     : build_ucast(cmd_mac, cmd_port, cmd_sec, cmd_blk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      cmd_mac <= '0;
      cmd_port <= '0;
      cmd_mask <= '0;
      cmd_sec <= 1'b0;
      cmd_blk <= 1'b0;
      hit_v <= 1'b0;
      free_v <= 1'b0;
      age_v <= 1'b0;
      hit_idx <= '0;
      free_idx <= '0;
      age_idx <= '0;
      hit_ent <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (clr_start) begin
            st  <= S_CLEAR;
            idx <= '0;
          end else if (accept) begin
            st       <= S_SCAN;
            idx      <= '0;
            cmd_mac  <= upd_mac;
            cmd_port <= upd_port;
            cmd_mask <= upd_mask;
            cmd_sec  <= upd_secure;
            cmd_blk  <= upd_blocked;
            hit_v    <= 1'b0;
            free_v   <= 1'b0;
            age_v    <= 1'b0;
          end
        end
        S_SCAN: begin
          if (!hit_v && has_addr(scan_entry) && (mac_of(scan_entry) == cmd_mac)) begin
            hit_v   <= 1'b1;
            hit_idx <= idx;
            hit_ent <= scan_entry;
          end
          if (!free_v && (kind_of(scan_entry) == KIND_FREE)) begin
            free_v   <= 1'b1;
            free_idx <= idx;
          end
          if (!age_v && is_ageable(scan_entry)) begin
            age_v   <= 1'b1;
            age_idx <= idx;
          end
          if (scan_last) st <= S_COMMIT;
          else           idx <= idx + 1'b1;
        end
        S_COMMIT: st <= S_IDLE;
        S_CLEAR: begin
          if (idx == LAST) st <= S_IDLE;
          else             idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scan_idx = idx;
  assign we       = ((st == S_COMMIT) && slot_found) || (st == S_CLEAR);
  assign wr_idx   = (st == S_CLEAR) ? idx : target_idx;
  assign wr_entry = (st == S_CLEAR) ? '0 : new_ent;
  assign busy     = (st != S_IDLE);
  assign clr_busy = (st == S_CLEAR);
  assign done     = (st == S_COMMIT) && slot_found;
  assign nospace  = (st == S_COMMIT) && !slot_found;

  // R12: a commit only follows the last slot of a complete walk
  p_commit_after_walk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COMMIT) |-> $past(scan_last));

  // R5: clearing visits consecutive slots, one per clock
  p_clear_consecutive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLEAR && idx != '0) |-> ($past(st == S_CLEAR) && idx == IDX_W'($past(idx) + 1'b1)));

  // R11: a request during a busy cycle never starts a new walk
  p_no_start_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && upd_valid) |=> !(st == S_SCAN && idx == '0));

  // R9: the no-space outcome never writes the table
  p_nospace_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nospace |-> !we);
endmodule

// File: rtl/alt_lookup_table.sv
module alt_lookup_table
  import alt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [7:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    upd_valid,
  input  logic [ALT_MAC_W-1:0]    upd_mac,
  input  logic [ALT_PNUM_W-1:0]   upd_port,
  input  logic [ALT_PORTS-1:0]    upd_mask,
  input  logic                    upd_secure,
  input  logic                    upd_blocked,
  output logic                    upd_busy,
  output logic                    upd_done,
  output logic                    upd_nospace,
  output logic [2*ALT_PORTS-1:0]  port_state
);
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_TCTL  = 8'h04;
  localparam logic [7:0] A_WHI   = 8'h08;
  localparam logic [7:0] A_WMID  = 8'h0C;
  localparam logic [7:0] A_WLO   = 8'h10;
  localparam logic [7:0] A_PORT0 = 8'h20;

  logic                  ctrl_en, ctrl_vlan;
  logic [ALT_HI_W-1:0]   w_hi;
  logic [31:0]           w_mid, w_lo;
  logic [IDX_W-1:0]      last_idx;
  logic [1:0]            pst [ALT_PORTS];

  logic                  busy, clr_busy, seq_we;
  logic [IDX_W-1:0]      seq_idx, seq_wr_idx, sw_idx;
  alt_entry_t            seq_entry, seq_wr_entry, sw_entry, st_wr_entry;
  logic                  clr_req, sw_load, sw_store, st_we;
  logic [IDX_W-1:0]      st_wr_idx;

  assign sw_idx   = reg_wdata[IDX_W-1:0];
  assign clr_req  = reg_we && (reg_addr == A_CTRL) && reg_wdata[30];
  assign sw_load  = reg_we && (reg_addr == A_TCTL) && !busy && !reg_wdata[31];
  assign sw_store = reg_we && (reg_addr == A_TCTL) && !busy && reg_wdata[31];

  assign st_we       = seq_we || sw_store;
  assign st_wr_idx   = seq_we ? seq_wr_idx : sw_idx;
  assign st_wr_entry = seq_we ? seq_wr_entry : {w_hi, w_mid, w_lo};

  alt_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(st_we), .wr_idx(st_wr_idx), .wr_entry(st_wr_entry),
    .a_idx(seq_idx), .a_entry(seq_entry),
    .b_idx(sw_idx), .b_entry(sw_entry)
  );

  alt_placer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_placer (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en),
    .upd_valid(upd_valid), .upd_mac(upd_mac), .upd_port(upd_port),
    .upd_mask(upd_mask), .upd_secure(upd_secure), .upd_blocked(upd_blocked),
    .clr_req(clr_req),
    .scan_idx(seq_idx), .scan_entry(seq_entry),
    .we(seq_we), .wr_idx(seq_wr_idx), .wr_entry(seq_wr_entry),
    .busy(busy), .clr_busy(clr_busy), .done(upd_done), .nospace(upd_nospace)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_vlan <= 1'b0;
      w_hi      <= '0;
      w_mid     <= '0;
      w_lo      <= '0;
      last_idx  <= '0;
      for (int p = 0; p < ALT_PORTS; p++) pst[p] <= 2'd0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) begin
        ctrl_en   <= reg_wdata[31];
        ctrl_vlan <= reg_wdata[2];
      end
      if (sw_load) {w_hi, w_mid, w_lo} <= sw_entry;
      if (sw_load || sw_store) last_idx <= sw_idx;
      if (reg_addr == A_WHI)  w_hi  <= reg_wdata[ALT_HI_W-1:0];
      if (reg_addr == A_WMID) w_mid <= reg_wdata;
      if (reg_addr == A_WLO)  w_lo  <= reg_wdata;
      for (int p = 0; p < ALT_PORTS; p++)
        if (reg_addr == A_PORT0 + 8'(4 * p)) pst[p] <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {ctrl_en, clr_busy, 27'd0, ctrl_vlan, 2'd0};
      A_TCTL:  reg_rdata = 32'(last_idx);
      A_WHI:   reg_rdata = 32'(w_hi);
      A_WMID:  reg_rdata = w_mid;
      A_WLO:   reg_rdata = w_lo;
      default: begin
        for (int p = 0; p < ALT_PORTS; p++)
          if (reg_addr == A_PORT0 + 8'(4 * p)) reg_rdata = {30'd0, pst[p]};
      end
    endcase
  end

  for (genvar g = 0; g < ALT_PORTS; g++) begin : g_pstate
    assign port_state[2*g +: 2] = pst[g];
  end

  assign upd_busy = busy;

  // R3: port states move only on a register write
  p_port_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(port_state));

  // R2: data words move only on a register write
  p_words_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable({w_hi, w_mid, w_lo}));

  // R11: the table never sees a software store during a busy cycle
  p_sw_store_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && reg_we && reg_addr == A_TCTL) |-> !sw_store);
endmodule

// File: tb/alt_lookup_table_test.sv
`timescale 1ns/1ps
module alt_lookup_table_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        upd_valid = 1'b0;
  logic [47:0] upd_mac = '0;
  logic [1:0]  upd_port = '0;
  logic [2:0]  upd_mask = '0;
  logic        upd_secure = 1'b0;
  logic        upd_blocked = 1'b0;
  logic        upd_busy, upd_done, upd_nospace;
  logic [5:0]  port_state;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  alt_lookup_table #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_valid(upd_valid),
    .upd_mac(upd_mac), .upd_port(upd_port), .upd_mask(upd_mask),
    .upd_secure(upd_secure), .upd_blocked(upd_blocked), .upd_busy(upd_busy),
    .upd_done(upd_done), .upd_nospace(upd_nospace), .port_state(port_state)
  );

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench-side entry builders, bit positions from the requirements
  function automatic logic [68:0] mk_uc(logic [47:0] mac, logic [1:0] cls,
                                        logic [1:0] port, logic sec, logic blk,
                                        logic [1:0] kind);
    logic [68:0] e = '0;
    e[47:0] = mac; e[61:60] = kind; e[63:62] = cls;
    e[64] = sec; e[65] = blk; e[67:66] = port;
    return e;
  endfunction

  function automatic logic [68:0] mk_mc(logic [47:0] mac, logic [1:0] fwd,
                                        logic [2:0] mask, logic sec);
    logic [68:0] e = '0;
    e[47:0] = mac; e[61:60] = 2'd1; e[63:62] = fwd;
    e[64] = sec; e[68:66] = mask;
    return e;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_entry(int idx, logic [68:0] e);
    wr(8'h08, {27'd0, e[68:64]});
    wr(8'h0C, e[63:32]);
    wr(8'h10, e[31:0]);
    wr(8'h04, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic get_entry(int idx, output logic [95:0] e);
    logic [31:0] h, m, l;
    wr(8'h04, 32'(idx));
    rd(8'h08, h); rd(8'h0C, m); rd(8'h10, l);
    e = {h, m, l};
  endtask

  task automatic do_update(logic [47:0] mac, logic [1:0] port, logic [2:0] mask,
                           logic sec, logic blk, output logic placed,
                           output logic nosp, output int lat);
    @(negedge clk);
    upd_mac = mac; upd_port = port; upd_mask = mask;
    upd_secure = sec; upd_blocked = blk; upd_valid = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
    placed = 1'b0; nosp = 1'b0; lat = -1;
    for (int j = 0; j < DEPTH + 8; j++) begin
      @(negedge clk);
      if (upd_done || upd_nospace) begin
        placed = upd_done; nosp = upd_nospace; lat = j;
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_clear(output int lat);
    logic [31:0] c;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'hC000_0000;
    @(negedge clk);
    reg_we = 1'b0;
    lat = 0;
    rd(8'h00, c);
    while (c[30] && lat < 4 * DEPTH) begin
      @(negedge clk);
      lat++;
      rd(8'h00, c);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [95:0] e;
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    for (int p = 0; p < 3; p++) begin
      rd(8'h20 + 8'(4 * p), d); chk("R1 port", d, 0);
    end
    rd(8'h08, d); chk("R1 word hi", d, 0);
    rd(8'h10, d); chk("R1 word lo", d, 0);
    chk("R1 flags", {upd_busy, upd_done, upd_nospace}, 0);
    get_entry(DEPTH - 1, e); chk("R1 slot", e, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h00, 32'h8000_0F04);
    rd(8'h00, d); chk("R4 ctrl bits", d, 32'h8000_0004);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); chk("R4 ctrl zero", d, 0);
  endtask

  task automatic t_ports();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFF2);
    wr(8'h24, 32'h0000_0003);
    wr(8'h28, 32'h1234_5671);
    rd(8'h20, d); chk("R3 port0", d, 2);
    rd(8'h28, d); chk("R3 port2", d, 1);
    chk("R3 port_state", port_state, 6'b01_11_10);
  endtask

  task automatic t_indirect();
    logic [95:0] e;
    logic [31:0] d;
    put_entry(7, {5'h15, 32'hDEAD_BEEF, 32'h0123_4567});
    put_entry(3, {5'h0A, 32'h5555_AAAA, 32'h89AB_CDEF});
    get_entry(7, e); chk("R2 slot7", e, {27'd0, 5'h15, 32'hDEAD_BEEF, 32'h0123_4567});
    get_entry(3, e); chk("R2 slot3", e, {27'd0, 5'h0A, 32'h5555_AAAA, 32'h89AB_CDEF});
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 hi word width", d, 32'h1F);
  endtask

  task automatic t_clear();
    int lat;
    logic [95:0] e;
    logic [31:0] d;
    put_entry(DEPTH - 1, mk_uc(48'h02_00_00_00_00_99, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1));
    do_clear(lat);
    chk("R5 clear length", lat, DEPTH);
    get_entry(DEPTH - 1, e); chk("R5 last slot freed", e, 0);
    get_entry(7, e); chk("R5 slot7 freed", e, 0);
    rd(8'h00, d); chk("R5 ctrl after clear", d, 32'h8000_0000);
  endtask

  task automatic t_ucast();
    logic pl, ns; int lat;
    logic [95:0] e;
    do_update(48'h02_11_22_33_44_55, 2'd2, 3'd0, 1'b1, 1'b0, pl, ns, lat);
    chk("R6 placed", {pl, ns}, 2'b10);
    chk("R12 latency", lat, DEPTH);
    get_entry(0, e);
    chk("R6 entry", e, 96'(mk_uc(48'h02_11_22_33_44_55, 2'd0, 2'd2, 1'b1, 1'b0, 2'd1)));
  endtask

  task automatic t_same();
    int lat; logic pl, ns;
    logic [95:0] e;
    do_clear(lat);
    put_entry(5, mk_uc(48'h02_AB_CD_00_00_05, 2'd3, 2'd0, 1'b1, 1'b1, 2'd3));
    do_update(48'h02_AB_CD_00_00_05, 2'd1, 3'd0, 1'b0, 1'b1, pl, ns, lat);
    chk("R7 placed", pl, 1);
    get_entry(5, e);
    chk("R7 overwrote match", e, 96'(mk_uc(48'h02_AB_CD_00_00_05, 2'd0, 2'd1, 1'b0, 1'b1, 2'd1)));
    get_entry(0, e); chk("R7 free slot untouched", e, 0);
  endtask

  task automatic t_age_full();
    int lat; logic pl, ns;
    logic [95:0] e;
    for (int i = 0; i < DEPTH; i++)
      put_entry(i, mk_uc({8'h02, 32'h0, 8'(i)}, 2'd0, 2'd0, 1'b0, 1'b0, 2'd1));
    put_entry(0, mk_uc(48'h02_00_00_00_0F_00, 2'd1, 2'd0, 1'b0, 1'b0, 2'd2));
    put_entry(1, mk_mc(48'h01_00_5E_00_00_07, 2'd1, 3'b001, 1'b0));
    put_entry(3, mk_uc(48'h02_00_00_00_00_33, 2'd2, 2'd0, 1'b0, 1'b0, 2'd1));
    put_entry(9, mk_uc(48'h02_00_00_00_00_99, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1));
    put_entry(12, mk_uc(48'h02_00_00_00_00_CC, 2'd3, 2'd0, 1'b0, 1'b0, 2'd3));
    do_update(48'h02_AA_BB_CC_DD_EE, 2'd1, 3'd0, 1'b0, 1'b0, pl, ns, lat);
    chk("R8 placed", {pl, ns}, 2'b10);
    get_entry(9, e);
    chk("R8 first ageable used", e, 96'(mk_uc(48'h02_AA_BB_CC_DD_EE, 2'd0, 2'd1, 1'b0, 1'b0, 2'd1)));
    get_entry(3, e);
    chk("R8 vendor-prefix kept", e, 96'(mk_uc(48'h02_00_00_00_00_33, 2'd2, 2'd0, 1'b0, 1'b0, 2'd1)));
    put_entry(12, mk_uc(48'h02_00_00_00_00_CC, 2'd0, 2'd0, 1'b0, 1'b0, 2'd3));
    do_update(48'h02_77_77_77_77_77, 2'd2, 3'd0, 1'b0, 1'b0, pl, ns, lat);
    chk("R9 no space", {pl, ns}, 2'b01);
    chk("R12 nospace latency", lat, DEPTH);
    get_entry(12, e);
    chk("R9 table unchanged", e, 96'(mk_uc(48'h02_00_00_00_00_CC, 2'd0, 2'd0, 1'b0, 1'b0, 2'd3)));
  endtask

  task automatic t_mcast();
    int lat; logic pl, ns;
    logic [95:0] e;
    do_clear(lat);
    put_entry(2, mk_mc(48'h01_00_5E_00_00_01, 2'd0, 3'b001, 1'b1));
    do_update(48'h01_00_5E_00_00_01, 2'd0, 3'b100, 1'b0, 1'b0, pl, ns, lat);
    chk("R10 placed", pl, 1);
    get_entry(2, e);
    chk("R10 mask merged", e, 96'(mk_mc(48'h01_00_5E_00_00_01, 2'd3, 3'b101, 1'b1)));
    do_update(48'h01_00_5E_00_00_02, 2'd0, 3'b010, 1'b0, 1'b0, pl, ns, lat);
    get_entry(0, e);
    chk("R10 new group", e, 96'(mk_mc(48'h01_00_5E_00_00_02, 2'd3, 3'b010, 1'b0)));
  endtask

  task automatic t_refuse();
    int lat, pulses;
    logic [95:0] e;
    do_clear(lat);
    wr(8'h00, 32'h0);
    @(negedge clk);
    upd_mac = 48'h02_01_01_01_01_01; upd_valid = 1'b1;
    pulses = 0;
    for (int j = 0; j < DEPTH + 4; j++) begin
      @(negedge clk);
      if (upd_done || upd_busy) pulses++;
    end
    upd_valid = 1'b0;
    chk("R11 disabled ignores request", pulses, 0);
    wr(8'h00, 32'h8000_0000);
    @(negedge clk);
    upd_mac = 48'h02_0A_0A_0A_0A_0A; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    upd_mac = 48'h02_0B_0B_0B_0B_0B; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    pulses = 0;
    for (int j = 0; j < 2 * DEPTH + 4; j++) begin
      @(negedge clk);
      if (upd_done) pulses++;
    end
    chk("R11 one placement while busy", pulses, 1);
    get_entry(1, e); chk("R11 second request not placed", e, 0);
    get_entry(0, e);
    chk("R11 first request placed", e, 96'(mk_uc(48'h02_0A_0A_0A_0A_0A, 2'd0, 2'd0, 1'b0, 1'b0, 2'd1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_ports();
    t_indirect();
    wr(8'h00, 32'h8000_0000);
    t_clear();
    t_ucast();
    t_same();
    t_age_full();
    t_mcast();
    t_refuse();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule